// File: doc/BRIEF.md
# Serial Configuration Image Loader

This block brings up a downstream programmable device that takes its configuration as a serial bit stream. After a `start` pulse, it switches on the device supply enable and waits for a settling time. It then parks the device lines, with the program line high and the clock and data lines low, for a short setup time. Next it holds the active-low program line low for a fixed time, releases it, and waits once more. Finally it streams a fixed-length image out on one data line, with one explicit clock strobe for every bit.

Image words are 32 bits wide by default and come from an external memory. The memory is reached through a request channel (`req_valid`/`req_ready` with an address) and a response channel (`rsp_valid`/`rsp_ready` with a data word). Back-pressure works as follows:
- A request stays valid with a stable address until the memory accepts it.
- Only one request is outstanding at a time.
- `rsp_ready` is high only while a request is outstanding and the one-word prefetch buffer is empty.
- A response presented at any other time is not taken.

If the next word has not arrived when the current word ends, the stream pauses with the clock low until it arrives.

`busy` covers the whole sequence. `done` rises when the last bit has been clocked and holds until the next `start`. The supply enable stays on after the sequence ends. Every delay is a count of units, and each unit is `DELAY_UNIT` system clocks.

Top module: `cfgld_loader`

## Requirements
- R1: While reset is held and after it is released with no start, `pwr_en`=0, `prog_n`=1, `cclk`=0, `din`=0, `busy`=0, `done`=0 and `req_valid`=0.
- R2: A start sampled while idle or done raises `pwr_en` from the next cycle onward, and it stays high until reset. `prog_n` then stays high, and `cclk` and `din` stay low, for exactly (PWR_UNITS+SETUP_UNITS)*DELAY_UNIT cycles before `prog_n` falls.
- R3: `prog_n` is low for exactly PROG_UNITS*DELAY_UNIT consecutive cycles, once per sequence, with `cclk` and `din` low throughout. No `cclk` rise follows the release by fewer than POST_UNITS*DELAY_UNIT+CCLK_LO cycles.
- R4: Each sequence produces exactly NUM_WORDS*WORD_W rising edges of `cclk`.
- R5: Words are sent in ascending address order from address 0, each one most significant bit first. The value on `din` while `cclk` is high is the bit being sent.
- R6: `din` takes its value at least one cycle before `cclk` rises and does not change while `cclk` is high. Each high phase lasts CCLK_HI cycles, and each low phase lasts at least CCLK_LO cycles.
- R7: A pending request holds `req_valid` with `req_addr` stable until `req_ready`. Addresses 0 to NUM_WORDS-1 are each requested once per sequence, in ascending order.
- R8: When the response for the next word is late, the stream pauses with `cclk` low and resumes with the correct bits. No bit is lost or repeated.
- R9: `busy` is high from the cycle after an accepted start until the cycle after the last bit. `done` rises as `busy` falls, holds while `start` is low, and clears in the cycle after a new start.
- R10: A start pulse during a running sequence is ignored: there is no second program pulse and no extra bits.
- R11: A start sampled in the same cycle that the last clock high phase ends is ignored. `done` still rises and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load sequence when idle or done |
| pwr_en | output | 1 | Device supply enable |
| prog_n | output | 1 | Active-low program pulse to the device |
| cclk | output | 1 | Configuration bit clock |
| din | output | 1 | Configuration bit data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last bit sent; held until next start |
| req_valid | output | 1 | Word read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Word address of the request |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Loader can take read data |
| rsp_data | input | WORD_W | Image word returned by memory |

## Verification
Two events can fall in the same cycle: the end of the final clock high phase and a new `start`. The bench provokes this by watching for the high phase of the last bit and raising `start` so that it is sampled on that very edge. It judges the result by three things: one program pulse for the run, the exact bit count, and `done` staying high afterward. Other runs overlap a slow or stalled memory response with the shifting of the current word, and check that the stream pauses with the clock low and no bit is lost.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PWR,
    LD_SETUP,
    LD_PROG,
    LD_POST,
    LD_SHIFT,
    LD_DONE
  } ld_state_e;

  typedef enum logic [1:0] {
    PH_WAIT,
    PH_LO,
    PH_HI
  } ph_e;
endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cfgld_fetch.sv
module cfgld_fetch #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 16,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              take,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              buf_valid,
  output logic [WORD_W-1:0] buf_data
);
  localparam int CNT_W = $clog2(NUM_WORDS + 1);

  logic [CNT_W-1:0] issued;
  logic             outstanding;

  assign req_valid = en && !outstanding && !buf_valid && (issued < CNT_W'(NUM_WORDS));
  assign req_addr  = ADDR_W'(issued);
  assign rsp_ready = en && outstanding && !buf_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued      <= '0;
      outstanding <= 1'b0;
      buf_valid   <= 1'b0;
      buf_data    <= '0;
    end else if (!en) begin
      issued      <= '0;
      outstanding <= 1'b0;
      buf_valid   <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        issued      <= issued + 1'b1;
        outstanding <= 1'b1;
      end
      if (rsp_valid && rsp_ready) begin
        buf_data    <= rsp_data;
        buf_valid   <= 1'b1;
        outstanding <= 1'b0;
      end else if (take) begin
        buf_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift
  import cfgld_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 16,
  parameter int CCLK_LO   = 1,
  parameter int CCLK_HI   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              buf_valid,
  input  logic [WORD_W-1:0] buf_data,
  output logic              take,
  output logic              cclk,
  output logic              din,
  output logic              fin
);
  localparam int CNT_W  = $clog2(NUM_WORDS + 1);
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int PH_MAX = (CCLK_LO > CCLK_HI) ? CCLK_LO : CCLK_HI;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  ph_e              ph;
  logic [PH_W-1:0]  ph_cnt;
  logic [BIT_W-1:0] bit_idx;
  logic [CNT_W-1:0] words;
  logic [WORD_W-1:0] sh;

  logic ph_end, last_bit, last_word;
  assign ph_end    = (ph_cnt == '0);
  assign last_bit  = (bit_idx == BIT_W'(WORD_W - 1));
  assign last_word = (words == CNT_W'(NUM_WORDS - 1));

  assign take = en && (ph == PH_WAIT) && buf_valid;
  assign fin  = en && (ph == PH_HI) && ph_end && last_bit && last_word;
  assign cclk = (ph == PH_HI);
  assign din  = (ph != PH_WAIT) && sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_WAIT;
      ph_cnt  <= '0;
      bit_idx <= '0;
      words   <= '0;
      sh      <= '0;
    end else if (!en) begin
      ph      <= PH_WAIT;
      bit_idx <= '0;
      words   <= '0;
    end else begin
      case (ph)
        PH_WAIT: if (buf_valid) begin
          sh      <= buf_data;
          bit_idx <= '0;
          ph      <= PH_LO;
          ph_cnt  <= PH_W'(CCLK_LO - 1);
        end
        PH_LO: if (ph_end) begin
          ph     <= PH_HI;
          ph_cnt <= PH_W'(CCLK_HI - 1);
        end else begin
          ph_cnt <= ph_cnt - 1'b1;
        end
        PH_HI: if (ph_end) begin
          if (last_bit) begin
            ph    <= PH_WAIT;
            words <= words + 1'b1;
          end else begin
            sh      <= sh << 1;
            bit_idx <= bit_idx + 1'b1;
            ph      <= PH_LO;
            ph_cnt  <= PH_W'(CCLK_LO - 1);
          end
        end else begin
          ph_cnt <= ph_cnt - 1'b1;
        end
        default: ph <= PH_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
  import cfgld_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 10524,
  parameter int DELAY_UNIT  = 1000,
  parameter int PWR_UNITS   = 50,
  parameter int SETUP_UNITS = 1,
  parameter int PROG_UNITS  = 50,
  parameter int POST_UNITS  = 1,
  parameter int CCLK_LO     = 1,
  parameter int CCLK_HI     = 1,
  localparam int ADDR_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              pwr_en,
  output logic              prog_n,
  output logic              cclk,
  output logic              din,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data
);
  localparam int PWR_CYC   = PWR_UNITS * DELAY_UNIT;
  localparam int SETUP_CYC = SETUP_UNITS * DELAY_UNIT;
  localparam int PROG_CYC  = PROG_UNITS * DELAY_UNIT;
  localparam int POST_CYC  = POST_UNITS * DELAY_UNIT;
  localparam int MAX_A     = (PWR_CYC > SETUP_CYC) ? PWR_CYC : SETUP_CYC;
  localparam int MAX_B     = (PROG_CYC > POST_CYC) ? PROG_CYC : POST_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);

  ld_state_e        st, st_nxt;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             fetch_en, shift_en, take, fin;
  logic             buf_valid;
  logic [WORD_W-1:0] buf_data;

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      LD_IDLE, LD_DONE: if (start) begin
        st_nxt = LD_PWR;   tmr_load = 1'b1; tmr_val = TMR_W'(PWR_CYC - 1);
      end
      LD_PWR: if (tmr_zero) begin
        st_nxt = LD_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CYC - 1);
      end
      LD_SETUP: if (tmr_zero) begin
        st_nxt = LD_PROG;  tmr_load = 1'b1; tmr_val = TMR_W'(PROG_CYC - 1);
      end
      LD_PROG: if (tmr_zero) begin
        st_nxt = LD_POST;  tmr_load = 1'b1; tmr_val = TMR_W'(POST_CYC - 1);
      end
      LD_POST:  if (tmr_zero) st_nxt = LD_SHIFT;
      LD_SHIFT: if (fin)      st_nxt = LD_DONE;
      default:  st_nxt = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LD_IDLE;
      pwr_en <= 1'b0;
    end else begin
      st <= st_nxt;
      if (st_nxt == LD_PWR) pwr_en <= 1'b1;
    end
  end

  assign prog_n   = (st != LD_PROG);
  assign busy     = (st != LD_IDLE) && (st != LD_DONE);
  assign done     = (st == LD_DONE);
  assign fetch_en = (st == LD_PROG) || (st == LD_POST) || (st == LD_SHIFT);
  assign shift_en = (st == LD_SHIFT);

  cfgld_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  cfgld_fetch #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .en(fetch_en), .take(take),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .buf_valid(buf_valid), .buf_data(buf_data)
  );

  cfgld_shift #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
                .CCLK_LO(CCLK_LO), .CCLK_HI(CCLK_HI)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .buf_valid(buf_valid),
    .buf_data(buf_data), .take(take), .cclk(cclk), .din(din), .fin(fin)
  );
endmodule

// File: rtl/cfgld_loader_chk.sv
module cfgld_loader_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              pwr_en,
  input logic              prog_n,
  input logic              cclk,
  input logic              din,
  input logic              busy,
  input logic              done,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr
);
  p_pwr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en |=> pwr_en);

  p_prog_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (!cclk && !din));

  p_din_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> $stable(din));

  p_cclk_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cclk |-> (busy && prog_n && pwr_en));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !req_valid && !cclk));
endmodule

bind cfgld_loader cfgld_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pwr_en(pwr_en), .prog_n(prog_n),
  .cclk(cclk), .din(din), .busy(busy), .done(done), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr)
);

// File: tb/cfgld_loader_test.sv
`timescale 1ns/1ps
module cfgld_loader_test;
  localparam int WORD_W = 32, NUM_WORDS = 3, DELAY_UNIT = 2;
  localparam int PWR_UNITS = 3, SETUP_UNITS = 1, PROG_UNITS = 4, POST_UNITS = 1;
  localparam int CCLK_LO = 1, CCLK_HI = 1;
  localparam int ADDR_W = 2;
  localparam int TOTAL = NUM_WORDS * WORD_W;
  localparam int PRE_CYC  = (PWR_UNITS + SETUP_UNITS) * DELAY_UNIT;
  localparam int PROG_CYC = PROG_UNITS * DELAY_UNIT;
  localparam int POST_MIN = POST_UNITS * DELAY_UNIT + CCLK_LO;

  typedef struct packed {
    logic [7:0]  rq_lat;
    logic [7:0]  rs_lat;
    logic [31:0] seed;
    logic        poke_mid;
    logic        poke_end;
    logic [7:0]  exp_pulses;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd0, 8'd0,  32'hC0DE_F00D, 1'b0, 1'b0, 8'd1},
    '{8'd2, 8'd3,  32'h1234_5678, 1'b1, 1'b0, 8'd1},
    '{8'd0, 8'd80, 32'hFFFF_0001, 1'b0, 1'b0, 8'd1},
    '{8'd0, 8'd0,  32'h8000_0000, 1'b0, 1'b1, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [WORD_W-1:0] rsp_data = '0;
  logic pwr_en, prog_n, cclk, din, busy, done, req_valid, rsp_ready;
  logic [ADDR_W-1:0] req_addr;

  always #2 clk = ~clk;

  cfgld_loader #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .DELAY_UNIT(DELAY_UNIT),
    .PWR_UNITS(PWR_UNITS), .SETUP_UNITS(SETUP_UNITS), .PROG_UNITS(PROG_UNITS),
    .POST_UNITS(POST_UNITS), .CCLK_LO(CCLK_LO), .CCLK_HI(CCLK_HI)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_en(pwr_en), .prog_n(prog_n),
    .cclk(cclk), .din(din), .busy(busy), .done(done), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [31:0] word_of(input logic [31:0] s, input int a);
    return s ^ (32'(a) * 32'h9E37_79B9) ^ (32'(a) << 24);
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // Per-run statistics
  logic [31:0] seed = '0;
  int rq_lat = 0, rs_lat = 0;
  int nbits = 0, bad_bits = 0, bad_setup = 0, bad_clk = 0, bad_busy = 0;
  int prog_low = 0, prog_pulses = 0, pre = 0, gap = 0;
  int exp_addr = 0, bad_addr = 0;
  int hi_run = 0, lo_run = 1000;
  logic p_cclk = 1'b0, p_din = 1'b0, p_prog = 1'b1;

  task automatic clear_stats();
    nbits = 0; bad_bits = 0; bad_setup = 0; bad_clk = 0; bad_busy = 0;
    prog_low = 0; prog_pulses = 0; pre = 0; gap = 0;
    exp_addr = 0; bad_addr = 0; lo_run = 1000;
  endtask

  // Output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (cclk && !p_cclk) begin
          logic [31:0] w;
          w = word_of(seed, nbits / WORD_W);
          if (din !== w[WORD_W-1 - (nbits % WORD_W)]) bad_bits++;
          if (din !== p_din) bad_setup++;
          if (lo_run < CCLK_LO) bad_clk++;
          nbits++;
        end
        if (cclk) hi_run++;
        else begin
          if (p_cclk) begin
            if (hi_run != CCLK_HI) bad_clk++;
            hi_run = 0;
            lo_run = 0;
          end
          lo_run++;
        end
        if (!prog_n) prog_low++;
        if (!prog_n && p_prog) prog_pulses++;
        if (busy && prog_pulses == 0 && prog_n) pre++;
        if (busy && prog_pulses > 0 && prog_n && nbits == 0 && !cclk) gap++;
        if ((cclk || !prog_n || req_valid) && !busy) bad_busy++;
      end
      p_cclk = cclk; p_din = din; p_prog = prog_n;
    end
  end

  // Memory model
  initial begin
    int mst, cnt;
    logic [ADDR_W-1:0] cur;
    mst = 0; cnt = 0; cur = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mst = 0; cnt = 0; req_ready = 0; rsp_valid = 0;
      end else begin
        case (mst)
          0: if (req_valid) begin
               if (cnt >= rq_lat) begin
                 req_ready = 1'b1; cur = req_addr;
                 if (int'(req_addr) != exp_addr) bad_addr++;
                 exp_addr++;
                 mst = 1;
               end else cnt++;
             end else cnt = 0;
          1: begin req_ready = 1'b0; cnt = 0; mst = 2; end
          2: if (cnt >= rs_lat) begin
               rsp_valid = 1'b1; rsp_data = word_of(seed, int'(cur)); mst = 3;
             end else cnt++;
          default: begin rsp_valid = 1'b0; cnt = 0; mst = 0; end
        endcase
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d (done never reached)", 0, 1);
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({pwr_en, prog_n, cclk, din, busy, done, req_valid} === 7'b0100000,
        "R1 outputs in reset", {pwr_en, prog_n, cclk, din, busy, done, req_valid}, 7'b0100000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({pwr_en, prog_n, cclk, din, busy, done, req_valid} === 7'b0100000,
        "R1 outputs idle after reset", {pwr_en, prog_n, cclk, din, busy, done, req_valid}, 7'b0100000);

    for (int v = 0; v < 4; v++) begin
      vec_t t;
      t = VECS[v];
      seed = t.seed; rq_lat = int'(t.rq_lat); rs_lat = int'(t.rs_lat);
      clear_stats();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R9 busy set, done clear after start",
          {busy, done}, 2'b10);
      chk(pwr_en === 1'b1, "R2 supply enable raised", pwr_en, 1);
      if (t.poke_mid) begin
        do begin @(negedge clk); #1; end while (nbits < 40);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
      if (t.poke_end) begin
        // R11: start lands on the edge ending the last high phase
        do begin @(negedge clk); #1; end while (!(cclk && nbits == TOTAL));
        start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(nbits == TOTAL, "R4 clock strobes per run", nbits, TOTAL);
      chk(bad_bits == 0, "R5 bit order and values", bad_bits, 0);
      chk(bad_setup == 0 && bad_clk == 0, "R6 data setup and clock phases",
          bad_setup + bad_clk, 0);
      chk(bad_addr == 0 && exp_addr == NUM_WORDS, "R7 request address sequence",
          exp_addr, NUM_WORDS);
      chk(pre == PRE_CYC, "R2 cycles before program pulse", pre, PRE_CYC);
      chk(prog_low == PROG_CYC, "R3 program pulse width", prog_low, PROG_CYC);
      chk(gap >= POST_MIN, "R3 wait after release", gap, POST_MIN);
      chk(prog_pulses == int'(t.exp_pulses), "R3 single program pulse", prog_pulses, t.exp_pulses);
      chk(done === 1'b1 && busy === 1'b0 && bad_busy == 0, "R9 done held, busy span",
          {done, busy}, 2'b10);
      if (t.rs_lat > 8'd64) chk(nbits == TOTAL && bad_bits == 0, "R8 stalled stream intact", bad_bits, 0);
      if (t.poke_mid) chk(prog_pulses == 1 && nbits == TOTAL, "R10 start while busy ignored", prog_pulses, 1);
      if (t.poke_end) chk(prog_pulses == 1 && done === 1'b1, "R11 start on final edge ignored", prog_pulses, 1);
    end

    // Done holds through a long idle stretch; supply stays on
    repeat (20) @(negedge clk);
    chk(done === 1'b1 && pwr_en === 1'b1 && cclk === 1'b0, "R9 done persists idle",
        {done, pwr_en, cclk}, 3'b110);

    // Reset mid-sequence returns to R1 state
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({pwr_en, prog_n, cclk, din, busy, done, req_valid} === 7'b0100000,
        "R1 reset during run", {pwr_en, prog_n, cclk, din, busy, done, req_valid}, 7'b0100000);
    summary();
  end
endmodule